// File: doc/BRIEF.md
# 8x8 Activation Tile Lossless Codec

This block packs 8-bit activation data one 8x8 tile (64 bytes) at a time and unpacks it again with no loss. The packer takes the tile in raster order, one byte per cycle, on a valid/ready byte stream. It then stalls its input while it sends out the packed form. Every packed tile opens with an occupancy bitmap that marks the non-zero elements, so tiles that are mostly zero (including zeros from padding) shrink to little more than the bitmap. When a tile holds at most four distinct non-zero values, those values are sent once as a small palette, followed by a 2-bit palette slot for each non-zero element. Tiles with more variety fall back to listing their non-zero bytes verbatim.

The unpacker reads the same byte stream on its own valid/ready port and rebuilds the 64 original bytes in raster order. The two halves are independent, so a tile packed on one side can be stored and later fed to the other side. Placing tiles in memory and cutting a feature map into tiles are left to the surrounding logic.

Packer states: `E_LOAD` (taking tile bytes) goes to `E_MASK` after the 64th byte. `E_MASK` goes to `E_MODE` after eight bitmap bytes. `E_MODE` then goes to `E_LOAD` for an empty tile, to `E_RAW` on palette overflow, or to `E_PAL` otherwise. `E_PAL` goes to `E_IDX` once the last palette entry is sent. `E_IDX` and `E_RAW` both return to `E_LOAD` after the last non-zero element. Unpacker states: `D_MASK` goes to `D_MODE` after eight bytes. `D_MODE` goes to `D_PAL` for a palette tile, or to `D_OUT` for a raw or empty tile. `D_PAL` goes to `D_OUT` after the last entry. `D_OUT` returns to `D_MASK` after the 64th output byte.

Top module: `fmap_block_codec`

## Requirements
- R1: The first eight packed bytes are the occupancy bitmap. In packed byte k, bit b is 1 exactly when tile element 8k+b (raster order) is non-zero.
- R2: The ninth packed byte is the mode byte. A tile with no non-zero element gives mode 8'h00, and its packed form ends there (9 bytes total).
- R3: A tile with 1 to 4 distinct non-zero values gives a mode byte equal to that count. The mode byte is followed by the distinct values in order of first appearance in raster order.
- R4: In palette mode, the palette is followed by ceil(nz/4) index bytes, where nz is the number of non-zero elements. Each non-zero element, in raster order, has a 2-bit slot number. The first slot in each byte sits in bits 1:0, the next in bits 3:2, and so on. Unused high bits are zero.
- R5: A tile with more than 4 distinct non-zero values gives mode byte 8'hFF, followed by every non-zero byte in raster order.
- R6: Feeding a packed tile to the unpacker yields the original 64 bytes exactly, in raster order.
- R7: The packer takes exactly 64 input bytes per tile and then holds enc_in_ready low until the packed form has been handed over. Bytes offered while enc_in_ready is low are not taken and do not affect any tile.
- R8: On both output ports, a byte presented with valid high stays unchanged, with valid still high, until ready is seen high.
- R9: While the unpacker's output is stalled in the middle of a tile, it takes no input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Tile byte offered to the packer |
| enc_in_ready | output | 1 | Packer takes the offered byte |
| enc_in_data | input | 8 | Tile byte, raster order |
| enc_out_valid | output | 1 | Packed byte available |
| enc_out_ready | input | 1 | Consumer takes the packed byte |
| enc_out_data | output | 8 | Packed byte |
| dec_in_valid | input | 1 | Packed byte offered to the unpacker |
| dec_in_ready | output | 1 | Unpacker takes the offered byte |
| dec_in_data | input | 8 | Packed byte |
| dec_out_valid | output | 1 | Rebuilt tile byte available |
| dec_out_ready | input | 1 | Consumer takes the rebuilt byte |
| dec_out_data | output | 8 | Rebuilt tile byte, raster order |

## Verification
The bench builds the block with its package defaults: 8-bit elements, 64-element tiles, a four-entry palette and 2-bit slots. With these values, the tile patterns can hit the exact edge between the palette form and the raw form (four versus five distinct values). They can also reach a fully dense tile at the raw form's worst length of 73 bytes, and an empty tile at the 9-byte minimum. Random output stalls on both ports exercise the hold rules and the unpacker's input gating partway through a tile.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

    localparam int BYTE_W       = 8;
    localparam int TILE_DIM     = 8;
    localparam int TILE_ELEMS   = TILE_DIM * TILE_DIM;
    localparam int PAL_MAX      = 4;
    localparam int IDX_W        = $clog2(PAL_MAX);
    localparam int IDX_PER_BYTE = BYTE_W / IDX_W;
    localparam int SUB_W        = $clog2(IDX_PER_BYTE);
    localparam int PTR_W        = $clog2(TILE_ELEMS);
    localparam int CNT_W        = $clog2(TILE_ELEMS + 1);
    localparam int PCNT_W       = $clog2(PAL_MAX + 1);
    localparam int MASK_BYTES   = TILE_ELEMS / BYTE_W;

    localparam logic [BYTE_W-1:0] MODE_EMPTY = 8'h00;
    localparam logic [BYTE_W-1:0] MODE_RAW   = 8'hFF;

    typedef enum logic [2:0] {
        E_LOAD, E_MASK, E_MODE, E_PAL, E_IDX, E_RAW
    } enc_state_t;

    typedef enum logic [1:0] {
        D_MASK, D_MODE, D_PAL, D_OUT
    } dec_state_t;

endpackage

// File: rtl/fmc_enc.sv
module fmc_enc
    import fmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);

    enc_state_t state_q, state_d;

    logic [BYTE_W-1:0]     blk_q [TILE_ELEMS];
    logic [IDX_W-1:0]      idx_q [TILE_ELEMS];
    logic [TILE_ELEMS-1:0] mask_q;
    logic [BYTE_W-1:0]     pal_q [PAL_MAX];
    logic [PCNT_W-1:0]     pal_cnt_q;
    logic                  ovf_q;
    logic [CNT_W-1:0]      nz_q, left_q, left_d;
    logic [PTR_W-1:0]      ptr_q, ptr_d;
    logic [SUB_W-1:0]      sub_q, sub_d;
    logic [BYTE_W-1:0]     acc_q, acc_d, acc_n;
    logic [BYTE_W-1:0]     emit_byte, mode_byte;
    logic                  slot_free, emit, done, accept, nz_in, hit;
    logic [PAL_MAX-1:0]    pal_hit;
    logic [IDX_W-1:0]      hit_idx;

    assign slot_free = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;
    assign nz_in     = (in_data != '0);

    generate
        for (genvar j = 0; j < PAL_MAX; j++) begin : g_cmp
            assign pal_hit[j] = (PCNT_W'(j) < pal_cnt_q) && (pal_q[j] == in_data);
        end
    endgenerate

    always_comb begin
        hit     = |pal_hit;
        hit_idx = '0;
        for (int j = PAL_MAX - 1; j >= 0; j--) begin
            if (pal_hit[j]) hit_idx = IDX_W'(j);
        end
    end

    always_comb begin
        if (nz_q == '0)  mode_byte = MODE_EMPTY;
        else if (ovf_q)  mode_byte = MODE_RAW;
        else             mode_byte = BYTE_W'(pal_cnt_q);
    end

    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        left_d    = left_q;
        sub_d     = sub_q;
        acc_d     = acc_q;
        acc_n     = acc_q;
        emit      = 1'b0;
        emit_byte = '0;
        in_ready  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            E_LOAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    ptr_d = ptr_q + 1'b1;
                    if (ptr_q == PTR_W'(TILE_ELEMS - 1)) begin
                        state_d = E_MASK;
                        ptr_d   = '0;
                    end
                end
            end
            E_MASK: begin
                if (slot_free) begin
                    emit      = 1'b1;
                    emit_byte = mask_q[32'(ptr_q) * BYTE_W +: BYTE_W];
                    ptr_d     = ptr_q + 1'b1;
                    if (ptr_q == PTR_W'(MASK_BYTES - 1)) begin
                        state_d = E_MODE;
                        ptr_d   = '0;
                    end
                end
            end
            E_MODE: begin
                if (slot_free) begin
                    emit      = 1'b1;
                    emit_byte = mode_byte;
                    ptr_d     = '0;
                    left_d    = nz_q;
                    if (nz_q == '0) begin
                        state_d = E_LOAD;
                        done    = 1'b1;
                    end else if (ovf_q) begin
                        state_d = E_RAW;
                    end else begin
                        state_d = E_PAL;
                    end
                end
            end
            E_PAL: begin
                if (slot_free) begin
                    emit      = 1'b1;
                    emit_byte = pal_q[ptr_q[IDX_W-1:0]];
                    ptr_d     = ptr_q + 1'b1;
                    if (ptr_q[PCNT_W-1:0] == pal_cnt_q - 1'b1) begin
                        state_d = E_IDX;
                        ptr_d   = '0;
                        sub_d   = '0;
                        acc_d   = '0;
                    end
                end
            end
            E_IDX: begin
                if (slot_free) begin
                    ptr_d = ptr_q + 1'b1;
                    if (mask_q[ptr_q]) begin
                        acc_n  = acc_q | (BYTE_W'(idx_q[ptr_q]) << (32'(sub_q) * IDX_W));
                        left_d = left_q - 1'b1;
                        if (sub_q == SUB_W'(IDX_PER_BYTE - 1) || left_q == CNT_W'(1)) begin
                            emit      = 1'b1;
                            emit_byte = acc_n;
                            acc_d     = '0;
                            sub_d     = '0;
                        end else begin
                            acc_d = acc_n;
                            sub_d = sub_q + 1'b1;
                        end
                        if (left_q == CNT_W'(1)) begin
                            state_d = E_LOAD;
                            ptr_d   = '0;
                            done    = 1'b1;
                        end
                    end
                end
            end
            E_RAW: begin
                if (slot_free) begin
                    ptr_d = ptr_q + 1'b1;
                    if (mask_q[ptr_q]) begin
                        emit      = 1'b1;
                        emit_byte = blk_q[ptr_q];
                        left_d    = left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state_d = E_LOAD;
                            ptr_d   = '0;
                            done    = 1'b1;
                        end
                    end
                end
            end
            default: state_d = E_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= E_LOAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            left_q    <= '0;
            sub_q     <= '0;
            acc_q     <= '0;
            pal_cnt_q <= '0;
            ovf_q     <= 1'b0;
            nz_q      <= '0;
            mask_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            ptr_q  <= ptr_d;
            left_q <= left_d;
            sub_q  <= sub_d;
            acc_q  <= acc_d;
            if (accept) begin
                blk_q[ptr_q]  <= in_data;
                mask_q[ptr_q] <= nz_in;
                if (nz_in) begin
                    nz_q <= nz_q + 1'b1;
                    if (hit) begin
                        idx_q[ptr_q] <= hit_idx;
                    end else if (pal_cnt_q < PCNT_W'(PAL_MAX)) begin
                        pal_q[pal_cnt_q[IDX_W-1:0]] <= in_data;
                        idx_q[ptr_q]                <= pal_cnt_q[IDX_W-1:0];
                        pal_cnt_q                   <= pal_cnt_q + 1'b1;
                    end else begin
                        ovf_q <= 1'b1;
                    end
                end
            end
            if (done) begin
                pal_cnt_q <= '0;
                ovf_q     <= 1'b0;
                nz_q      <= '0;
            end
            if (emit) begin
                out_valid <= 1'b1;
                out_data  <= emit_byte;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fmc_dec.sv
module fmc_dec
    import fmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);

    dec_state_t state_q, state_d;

    logic [TILE_ELEMS-1:0] mask_q;
    logic [BYTE_W-1:0]     pal_q [PAL_MAX];
    logic [PCNT_W-1:0]     pal_cnt_q;
    logic                  raw_q;
    logic [PTR_W-1:0]      ptr_q, ptr_d;
    logic [SUB_W-1:0]      sub_q, sub_d;
    logic [BYTE_W-1:0]     sh_q, sh_d;
    logic [BYTE_W-1:0]     emit_byte;
    logic                  slot_free, emit, adv, accept;

    assign slot_free = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;

    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        sub_d     = sub_q;
        sh_d      = sh_q;
        in_ready  = 1'b0;
        emit      = 1'b0;
        emit_byte = '0;
        adv       = 1'b0;
        unique case (state_q)
            D_MASK: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    ptr_d = ptr_q + 1'b1;
                    if (ptr_q == PTR_W'(MASK_BYTES - 1)) begin
                        state_d = D_MODE;
                        ptr_d   = '0;
                    end
                end
            end
            D_MODE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    ptr_d = '0;
                    sub_d = '0;
                    if (in_data == MODE_EMPTY || in_data == MODE_RAW) state_d = D_OUT;
                    else                                              state_d = D_PAL;
                end
            end
            D_PAL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    ptr_d = ptr_q + 1'b1;
                    if (ptr_q[PCNT_W-1:0] == pal_cnt_q - 1'b1) begin
                        state_d = D_OUT;
                        ptr_d   = '0;
                    end
                end
            end
            D_OUT: begin
                if (slot_free) begin
                    if (!mask_q[ptr_q]) begin
                        emit = 1'b1;
                        adv  = 1'b1;
                    end else if (raw_q) begin
                        in_ready = 1'b1;
                        if (in_valid) begin
                            emit      = 1'b1;
                            emit_byte = in_data;
                            adv       = 1'b1;
                        end
                    end else if (sub_q == '0) begin
                        in_ready = 1'b1;
                        if (in_valid) begin
                            emit      = 1'b1;
                            emit_byte = pal_q[in_data[IDX_W-1:0]];
                            sh_d      = in_data >> IDX_W;
                            sub_d     = SUB_W'(1);
                            adv       = 1'b1;
                        end
                    end else begin
                        emit      = 1'b1;
                        emit_byte = pal_q[sh_q[IDX_W-1:0]];
                        sh_d      = sh_q >> IDX_W;
                        sub_d     = sub_q + 1'b1;
                        adv       = 1'b1;
                    end
                end
                if (adv) begin
                    ptr_d = ptr_q + 1'b1;
                    if (ptr_q == PTR_W'(TILE_ELEMS - 1)) begin
                        state_d = D_MASK;
                        ptr_d   = '0;
                    end
                end
            end
            default: state_d = D_MASK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= D_MASK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            pal_cnt_q <= '0;
            raw_q     <= 1'b0;
            ptr_q     <= '0;
            sub_q     <= '0;
            sh_q      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            ptr_q <= ptr_d;
            sub_q <= sub_d;
            sh_q  <= sh_d;
            if (accept && state_q == D_MASK)
                mask_q[32'(ptr_q) * BYTE_W +: BYTE_W] <= in_data;
            if (accept && state_q == D_MODE) begin
                raw_q     <= (in_data == MODE_RAW);
                pal_cnt_q <= in_data[PCNT_W-1:0];
            end
            if (accept && state_q == D_PAL)
                pal_q[ptr_q[IDX_W-1:0]] <= in_data;
            if (emit) begin
                out_valid <= 1'b1;
                out_data  <= emit_byte;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fmap_block_codec.sv
module fmap_block_codec
    import fmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_in_valid,
    output logic              enc_in_ready,
    input  logic [BYTE_W-1:0] enc_in_data,
    output logic              enc_out_valid,
    input  logic              enc_out_ready,
    output logic [BYTE_W-1:0] enc_out_data,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [BYTE_W-1:0] dec_in_data,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [BYTE_W-1:0] dec_out_data
);

    fmc_enc enc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_in_data),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_data  (enc_out_data)
    );

    fmc_dec dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_data   (dec_in_data),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_data  (dec_out_data)
    );

endmodule

// File: rtl/fmc_codec_chk.sv
module fmc_codec_chk
    import fmc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enc_in_valid,
    input logic              enc_in_ready,
    input logic              enc_out_valid,
    input logic              enc_out_ready,
    input logic [BYTE_W-1:0] enc_out_data,
    input logic              dec_in_ready,
    input logic              dec_out_valid,
    input logic              dec_out_ready,
    input logic [BYTE_W-1:0] dec_out_data
);

    logic [PTR_W-1:0] enc_taken_q;
    logic [PTR_W-1:0] dec_given_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_taken_q <= '0;
            dec_given_q <= '0;
        end else begin
            if (enc_in_valid && enc_in_ready)   enc_taken_q <= enc_taken_q + 1'b1;
            if (dec_out_valid && dec_out_ready) dec_given_q <= dec_given_q + 1'b1;
        end
    end

    AST_ENC_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_data)); // R8

    AST_DEC_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data)); // R8

    AST_ENC_FULL_TILE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enc_in_ready) |-> enc_taken_q == '0); // R7

    AST_DEC_STALL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_ready && dec_given_q != PTR_W'(TILE_ELEMS - 1)
        |-> !dec_in_ready); // R9

endmodule

bind fmap_block_codec fmc_codec_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enc_in_valid  (enc_in_valid),
    .enc_in_ready  (enc_in_ready),
    .enc_out_valid (enc_out_valid),
    .enc_out_ready (enc_out_ready),
    .enc_out_data  (enc_out_data),
    .dec_in_ready  (dec_in_ready),
    .dec_out_valid (dec_out_valid),
    .dec_out_ready (dec_out_ready),
    .dec_out_data  (dec_out_data)
);

// File: tb/fmap_block_codec_tb_top.sv
module fmap_block_codec_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_in_valid = 1'b0, enc_in_ready;
    logic [7:0] enc_in_data = '0;
    logic       enc_out_valid, enc_out_ready = 1'b0;
    logic [7:0] enc_out_data;
    logic       dec_in_valid = 1'b0, dec_in_ready;
    logic [7:0] dec_in_data = '0;
    logic       dec_out_valid, dec_out_ready = 1'b0;
    logic [7:0] dec_out_data;

    always #2 clk = ~clk;

    fmap_block_codec dut_i (.*);

    typedef struct packed {
        logic [3:0] kind;
        logic       stall;
        logic [7:0] mode;
    } vec_t;

    // kind: 0 empty, 1 sparse random, 2 four values, 3 five values, 4 dense distinct,
    // 5 dense single value, 6 padded border two values, 7 random from three values
    // mode 8'hEE: mode not fixed in advance
    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 1'b0, 8'h00}, '{4'd1, 1'b0, 8'hEE}, '{4'd2, 1'b0, 8'h04},
        '{4'd3, 1'b0, 8'hFF}, '{4'd4, 1'b0, 8'hFF}, '{4'd5, 1'b0, 8'h01},
        '{4'd6, 1'b0, 8'h02}, '{4'd7, 1'b1, 8'hEE}, '{4'd0, 1'b1, 8'h00},
        '{4'd2, 1'b1, 8'h04}, '{4'd3, 1'b1, 8'hFF}, '{4'd4, 1'b1, 8'hFF},
        '{4'd1, 1'b1, 8'hEE}
    };

    int         n_checks = 0;
    int         n_fail   = 0;
    int         cyc      = 0;
    logic       stall_mode = 1'b0;
    logic [7:0] blk   [64];
    logic [7:0] exp_s [80];
    logic [7:0] got_s [80];
    logic [7:0] dec_s [64];
    int         exp_len, got_len, dec_len;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL R6 watchdog expired: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic gen_block(input logic [3:0] kind);
        logic [7:0] four [4] = '{8'd5, 8'd9, 8'd200, 8'd77};
        logic [7:0] five [5] = '{8'd12, 8'd34, 8'd56, 8'd78, 8'd90};
        logic [7:0] three [3] = '{8'h03, 8'h40, 8'h81};
        for (int i = 0; i < 64; i++) begin
            int r = i / 8;
            int c = i % 8;
            case (kind)
                4'd0: blk[i] = 8'h00;
                4'd1: blk[i] = ($urandom % 4 == 0) ? 8'(($urandom % 255) + 1) : 8'h00;
                4'd2: blk[i] = (i % 3 != 0) ? four[i % 4] : 8'h00;
                4'd3: blk[i] = (i % 2 == 1) ? five[i % 5] : 8'h00;
                4'd4: blk[i] = 8'(i + 1);
                4'd5: blk[i] = 8'h33;
                4'd6: blk[i] = (r == 0 || r == 7 || c == 0 || c == 7) ? 8'h00 :
                               (((r + c) % 2) != 0 ? 8'h11 : 8'hF0);
                default: blk[i] = ($urandom % 2 == 0) ? three[$urandom % 3] : 8'h00;
            endcase
        end
    endtask

    // Packed form computed from R1..R5
    task automatic model();
        logic [7:0] uniq [64];
        int nu = 0;
        int nz = 0;
        exp_len = 0;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] m = '0;
            for (int b = 0; b < 8; b++) if (blk[8*k+b] != 0) m[b] = 1'b1;
            exp_s[exp_len++] = m;
        end
        for (int i = 0; i < 64; i++) begin
            if (blk[i] != 0) begin
                bit seen = 0;
                nz++;
                for (int u = 0; u < nu; u++) if (uniq[u] == blk[i]) seen = 1;
                if (!seen) uniq[nu++] = blk[i];
            end
        end
        if (nz == 0) begin
            exp_s[exp_len++] = 8'h00;
        end else if (nu > 4) begin
            exp_s[exp_len++] = 8'hFF;
            for (int i = 0; i < 64; i++) if (blk[i] != 0) exp_s[exp_len++] = blk[i];
        end else begin
            logic [7:0] acc = '0;
            int sub = 0;
            exp_s[exp_len++] = 8'(nu);
            for (int u = 0; u < nu; u++) exp_s[exp_len++] = uniq[u];
            for (int i = 0; i < 64; i++) begin
                if (blk[i] != 0) begin
                    int slot = 0;
                    for (int u = 0; u < nu; u++) if (uniq[u] == blk[i]) slot = u;
                    acc = acc | (8'(slot) << (2 * sub));
                    sub++;
                    if (sub == 4) begin
                        exp_s[exp_len++] = acc;
                        acc = '0;
                        sub = 0;
                    end
                end
            end
            if (sub != 0) exp_s[exp_len++] = acc;
        end
    endtask

    task automatic feed_enc();
        int i = 0;
        while (i < 64) begin
            @(negedge clk);
            enc_in_valid = 1'b1;
            enc_in_data  = blk[i];
            #1;
            if (enc_in_ready) i++;
        end
        @(negedge clk);
        enc_in_valid = 1'b0;
    endtask

    task automatic collect_enc();
        int t = 0;
        while (got_len < exp_len && t < 2000) begin
            @(posedge clk);
            #1;
            enc_out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
            @(negedge clk);
            #1;
            if (enc_out_valid && enc_out_ready) got_s[got_len++] = enc_out_data;
            t++;
        end
        @(posedge clk);
        #1;
        enc_out_ready = 1'b1;
        for (int x = 0; x < 6; x++) begin
            @(negedge clk);
            #1;
            if (enc_out_valid) begin
                if (got_len < 80) got_s[got_len] = enc_out_data;
                got_len++;
            end
        end
    endtask

    task automatic feed_dec();
        int i = 0;
        while (i < got_len && i < 80) begin
            @(negedge clk);
            dec_in_valid = 1'b1;
            dec_in_data  = got_s[i];
            #1;
            if (dec_in_ready) i++;
        end
        @(negedge clk);
        dec_in_valid = 1'b0;
    endtask

    task automatic collect_dec();
        int t = 0;
        dec_len = 0;
        while (dec_len < 64 && t < 3000) begin
            @(posedge clk);
            #1;
            dec_out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
            @(negedge clk);
            #1;
            if (dec_out_valid && dec_out_ready) dec_s[dec_len++] = dec_out_data;
            t++;
        end
        @(posedge clk);
        #1;
        dec_out_ready = 1'b0;
    endtask

    task automatic check_encoding(input logic [7:0] mode_exp);
        int bad = -1;
        string req;
        for (int i = exp_len - 1; i >= 0; i--) if (got_s[i] != exp_s[i]) bad = i;
        // R1: bitmap bytes
        check(got_len >= 8 && (bad < 0 || bad >= 8), "R1", "bitmap byte",
              (bad >= 0 && bad < 8) ? int'(got_s[bad]) : 0,
              (bad >= 0 && bad < 8) ? int'(exp_s[bad]) : 0);
        if (exp_s[8] == 8'h00)      req = "R2";
        else if (exp_s[8] == 8'hFF) req = "R5";
        else                        req = "R3/R4";
        check(got_len == exp_len, req, "packed length", got_len, exp_len);
        check(bad < 0, req, "packed byte", bad >= 0 ? int'(got_s[bad]) : 0,
              bad >= 0 ? int'(exp_s[bad]) : 0);
        if (mode_exp != 8'hEE)
            check(got_s[8] == mode_exp, req, "mode byte", got_s[8], mode_exp);
    endtask

    task automatic check_roundtrip();
        int bad = -1;
        for (int i = 63; i >= 0; i--) if (dec_s[i] != blk[i]) bad = i;
        check(dec_len == 64, "R6", "rebuilt count", dec_len, 64);
        check(bad < 0, "R6", "rebuilt byte", bad >= 0 ? int'(dec_s[bad]) : 0,
              bad >= 0 ? int'(blk[bad]) : 0);
    endtask

    task automatic run_tile(input logic [3:0] kind, input logic st, input logic [7:0] mode_exp);
        stall_mode = st;
        gen_block(kind);
        model();
        got_len = 0;
        fork
            feed_enc();
            collect_enc();
        join
        check_encoding(mode_exp);
        fork
            feed_dec();
            collect_dec();
        join
        check_roundtrip();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R7: idle packer ready for a tile, nothing on the outputs
        check(enc_in_ready == 1'b1, "R7", "reset enc_in_ready", enc_in_ready, 1);
        check(enc_out_valid == 1'b0, "R8", "reset enc_out_valid", enc_out_valid, 0);
        check(dec_out_valid == 1'b0, "R9", "reset dec_out_valid", dec_out_valid, 0);
        check(dec_in_ready == 1'b1, "R9", "reset dec_in_ready", dec_in_ready, 1);

        for (int v = 0; v < NVEC; v++) run_tile(VECS[v].kind, VECS[v].stall, VECS[v].mode);

        // Directed: stalled packer output, stray input offered meanwhile
        stall_mode = 1'b0;
        enc_out_ready = 1'b0;
        gen_block(4'd5);
        model();
        feed_enc();
        @(negedge clk);
        #1;
        check(enc_in_ready == 1'b0, "R7", "in_ready while packing", enc_in_ready, 0);
        check(enc_out_valid && enc_out_data == exp_s[0], "R8", "first byte held",
              enc_out_data, exp_s[0]);
        enc_in_valid = 1'b1;
        enc_in_data  = 8'hAA;
        for (int x = 0; x < 4; x++) begin
            @(negedge clk);
            #1;
            check(enc_out_valid && enc_out_data == exp_s[0], "R8", "byte stable under stall",
                  enc_out_data, exp_s[0]);
            check(enc_in_ready == 1'b0, "R7", "stray byte refused", enc_in_ready, 0);
        end
        enc_in_valid = 1'b0;
        got_len = 0;
        collect_enc();
        check_encoding(8'h01);

        // R7: following tile unaffected by the refused bytes
        run_tile(4'd3, 1'b0, 8'hFF);
        // R9: decoder under stalls after a dense tile
        run_tile(4'd4, 1'b1, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule